// File: doc/BRIEF.md
# NAND Page Hamming Code Generator

This block sits beside the byte data path of a NAND flash controller and builds a single-error-correcting Hamming code over the bytes that pass through it. Each 256-byte chunk gets a 3-byte code made of sixteen line parities and six column parities. Software compares this code with the one stored in the spare area and corrects the error itself.

A 2-bit mode input drives the generator. The mode can clear the parity state, accumulate bytes, stop, or read the code out. In readout mode each read request returns one code byte a cycle later, on the same byte lane the data path uses. When the wide-block input is set, the first 256 bytes of a 512-byte block go to one code and the next 256 bytes go to a second code, and readout returns six bytes.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset `ecc_vld` and `ecc_byte` are 0, and a readout with no bytes accumulated returns 0xFF for every code byte.
- R2: Mode 2'b11 clears all parity state. A following readout returns 0xFF, 0xFF, 0xFF for each code, which is also the code of an all-0xFF chunk. Clearing also restarts the byte count at chunk 0, byte 0.
- R3: A byte strobe changes the code only when the mode is 2'b01. Bytes strobed in mode 2'b00 or 2'b10 leave every code unchanged.
- R4: Code layout. Let p be the XOR of the 8 bits of the byte at chunk index i. For each index bit k, line parity L[2k+1] toggles with p when i[k]=1, and L[2k] toggles with p when i[k]=0. Column parity C[2j+1] is the XOR of all data bits at positions whose bit j is 1, and C[2j] covers positions whose bit j is 0. Code byte 0 is ~L[7:0]. Code byte 1 is ~L[15:8]. Code byte 2 is {~C[5:0], 2'b11}.
- R5: Within each triplet, successive reads return code byte 1, then code byte 0, then code byte 2.
- R6: A read request in mode 2'b10 gives `ecc_vld`=1 with the byte on `ecc_byte` one clock later. A read request in any other mode gives no `ecc_vld`.
- R7: With `wide_blk`=1, accumulated bytes 0..255 feed code 0 and bytes 256..511 feed code 1. Readout returns triplet 0 and then triplet 1, and the seventh read wraps back to the first byte of triplet 0.
- R8: With `wide_blk`=0, every byte feeds code 0, code 1 does not change, and the fourth read wraps back to the first byte of triplet 0.
- R9: The readout pointer returns to the start whenever the mode is not 2'b10.
- R10: The byte count advances by one for each byte accepted in mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 stop, 01 accumulate, 10 readout, 11 clear |
| wide_blk | input | 1 | 1: 512-byte block with two codes; 0: 256-byte block |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| rd_req | input | 1 | Request the next code byte |
| ecc_byte | output | 8 | Code byte returned |
| ecc_vld | output | 1 | `ecc_byte` is valid this cycle |

## Verification
In readout mode a data byte strobe and a read request can arrive in the same cycle. The bench provokes this by keeping `byte_vld` high with changing data while it issues reads. It then judges the result by requiring each returned byte to equal the code of the bytes accumulated before readout began. A read request made while the mode is accumulate can also coincide with a data strobe. There the bench expects the byte to be folded into the code and no `ecc_vld` to appear.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_ACC  = 2'b01,
    MODE_READ = 2'b10,
    MODE_CLR  = 2'b11
  } ecc_mode_e;

  // XOR of all bits of a byte
  function automatic logic byte_par(input logic [7:0] d);
    return ^d;
  endfunction

  // Six column parities: [2j+1] over bit positions with bit j set, [2j] with it clear
  function automatic logic [5:0] col_par(input logic [7:0] d);
    logic [5:0] c;
    c[0] = d[0] ^ d[2] ^ d[4] ^ d[6];
    c[1] = d[1] ^ d[3] ^ d[5] ^ d[7];
    c[2] = d[0] ^ d[1] ^ d[4] ^ d[5];
    c[3] = d[2] ^ d[3] ^ d[6] ^ d[7];
    c[4] = d[0] ^ d[1] ^ d[2] ^ d[3];
    c[5] = d[4] ^ d[5] ^ d[6] ^ d[7];
    return c;
  endfunction

  // Readout slot within a triplet -> stored code byte (1, 0, 2)
  function automatic logic [1:0] slot_to_byte(input logic [1:0] slot);
    case (slot)
      2'd0:    return 2'd1;
      2'd1:    return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int MAX_CHUNKS = 2,
  localparam int CSEL_W    = $clog2(MAX_CHUNKS),
  localparam int CNT_W     = IDX_W + CSEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ecc_mode_e             mode,
  input  logic                  wide_blk,
  input  logic                  byte_vld,
  input  logic                  rd_req,
  output logic                  acc_fire,
  output logic                  clr_fire,
  output logic                  rd_fire,
  output logic [MAX_CHUNKS-1:0] chunk_sel,
  output logic [IDX_W-1:0]      byte_idx,
  output logic [CNT_W-1:0]      byte_cnt,
  output logic [1:0]            rd_pos,
  output logic [CSEL_W-1:0]     rd_tri
);

  logic [CSEL_W-1:0] chunk_now;
  logic [CSEL_W-1:0] tri_last;

  assign clr_fire  = (mode == MODE_CLR);
  assign acc_fire  = byte_vld && (mode == MODE_ACC);
  assign rd_fire   = rd_req && (mode == MODE_READ);
  assign byte_idx  = byte_cnt[IDX_W-1:0];
  assign chunk_now = wide_blk ? byte_cnt[CNT_W-1 -: CSEL_W] : '0;
  assign tri_last  = wide_blk ? CSEL_W'(MAX_CHUNKS - 1) : '0;

  for (genvar c = 0; c < MAX_CHUNKS; c++) begin : g_sel
    assign chunk_sel[c] = acc_fire && (chunk_now == CSEL_W'(c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_fire) begin
      byte_cnt <= '0;
    end else if (acc_fire) begin
      byte_cnt <= byte_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode != MODE_READ) begin
      rd_pos <= 2'd0;
      rd_tri <= '0;
    end else if (rd_fire) begin
      if (rd_pos == 2'd2) begin
        rd_pos <= 2'd0;
        rd_tri <= (rd_tri >= tri_last) ? '0 : rd_tri + 1'b1;
      end else begin
        rd_pos <= rd_pos + 2'd1;
      end
    end
  end

endmodule

// File: rtl/ecc_chunk_acc.sv
module ecc_chunk_acc
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W     = 8,
  localparam int LP_W     = 2 * IDX_W,
  localparam int CODE_W   = LP_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        data,
  output logic [CODE_W-1:0] code
);

  logic [LP_W-1:0] lp_q;
  logic [5:0]      cp_q;

  // Which line parities a byte at this index feeds
  function automatic logic [LP_W-1:0] line_mask(input logic [IDX_W-1:0] i);
    logic [LP_W-1:0] m;
    for (int k = 0; k < IDX_W; k++) begin
      m[2*k+1] = i[k];
      m[2*k]   = ~i[k];
    end
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (upd) begin
      lp_q <= lp_q ^ (byte_par(data) ? line_mask(idx) : '0);
      cp_q <= cp_q ^ col_par(data);
    end
  end

  assign code = {~cp_q, 2'b11, ~lp_q};

endmodule

// File: rtl/ecc_read_mux.sv
module ecc_read_mux
  import nand_ecc_pkg::*;
#(
  parameter int MAX_CHUNKS = 2,
  parameter int CODE_W     = 24,
  localparam int CSEL_W    = $clog2(MAX_CHUNKS)
) (
  input  logic [MAX_CHUNKS-1:0][CODE_W-1:0] codes,
  input  logic [CSEL_W-1:0]                 rd_tri,
  input  logic [1:0]                        rd_pos,
  output logic [7:0]                        rd_byte
);

  logic [1:0]        which;
  logic [CODE_W-1:0] sel_code;

  assign which    = slot_to_byte(rd_pos);
  assign sel_code = codes[rd_tri];
  assign rd_byte  = sel_code[8*which +: 8];

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  parameter int MAX_CHUNKS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       wide_blk,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       rd_req,
  output logic [7:0] ecc_byte,
  output logic       ecc_vld
);

  localparam int IDX_W  = $clog2(CHUNK_BYTES);
  localparam int CSEL_W = $clog2(MAX_CHUNKS);
  localparam int CNT_W  = IDX_W + CSEL_W;
  localparam int CODE_W = 2 * IDX_W + 8;

  logic                             acc_fire;
  logic                             clr_fire;
  logic                             rd_fire;
  logic [MAX_CHUNKS-1:0]            chunk_sel;
  logic [IDX_W-1:0]                 byte_idx;
  logic [CNT_W-1:0]                 byte_cnt;
  logic [1:0]                       rd_pos;
  logic [CSEL_W-1:0]                rd_tri;
  logic [MAX_CHUNKS-1:0][CODE_W-1:0] chunk_codes;
  logic [7:0]                       rd_byte;

  ecc_mode_ctrl #(.IDX_W(IDX_W), .MAX_CHUNKS(MAX_CHUNKS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (ecc_mode_e'(mode)),
    .wide_blk  (wide_blk),
    .byte_vld  (byte_vld),
    .rd_req    (rd_req),
    .acc_fire  (acc_fire),
    .clr_fire  (clr_fire),
    .rd_fire   (rd_fire),
    .chunk_sel (chunk_sel),
    .byte_idx  (byte_idx),
    .byte_cnt  (byte_cnt),
    .rd_pos    (rd_pos),
    .rd_tri    (rd_tri)
  );

  for (genvar c = 0; c < MAX_CHUNKS; c++) begin : g_chunk
    ecc_chunk_acc #(.IDX_W(IDX_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_fire),
      .upd   (chunk_sel[c]),
      .idx   (byte_idx),
      .data  (byte_data),
      .code  (chunk_codes[c])
    );
  end

  ecc_read_mux #(.MAX_CHUNKS(MAX_CHUNKS), .CODE_W(CODE_W)) u_mux (
    .codes   (chunk_codes),
    .rd_tri  (rd_tri),
    .rd_pos  (rd_pos),
    .rd_byte (rd_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecc_byte <= 8'h00;
      ecc_vld  <= 1'b0;
    end else begin
      ecc_vld <= rd_fire;
      if (rd_fire) ecc_byte <= rd_byte;
    end
  end

endmodule

// File: rtl/ecc_gen_chk.sv
module ecc_gen_chk #(
  parameter int MAX_CHUNKS = 2,
  parameter int CODE_W     = 24,
  parameter int CNT_W      = 9,
  parameter int CSEL_W     = 1
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [1:0]                       mode,
  input logic                             wide_blk,
  input logic                             rd_req,
  input logic                             ecc_vld,
  input logic                             acc_fire,
  input logic [CNT_W-1:0]                 byte_cnt,
  input logic [1:0]                       rd_pos,
  input logic [CSEL_W-1:0]                rd_tri,
  input logic [MAX_CHUNKS-1:0][CODE_W-1:0] codes
);

  // R2
  clear_erased_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> (&codes));

  // R3
  ignore_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b10) |=> $stable(codes));

  // R6
  vld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_vld |-> $past(rd_req && mode == 2'b10));

  // R9
  ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) |=> (rd_pos == 2'd0 && rd_tri == '0));

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && mode == 2'b01) |=> (byte_cnt == $past(byte_cnt) + 1'b1));

  // R8
  narrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_blk && mode != 2'b11) |=> $stable(codes[MAX_CHUNKS-1]));

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pos != 2'd3);

endmodule

bind nand_ecc_gen ecc_gen_chk #(
  .MAX_CHUNKS (MAX_CHUNKS),
  .CODE_W     (CODE_W),
  .CNT_W      (CNT_W),
  .CSEL_W     (CSEL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .wide_blk (wide_blk),
  .rd_req   (rd_req),
  .ecc_vld  (ecc_vld),
  .acc_fire (acc_fire),
  .byte_cnt (byte_cnt),
  .rd_pos   (rd_pos),
  .rd_tri   (rd_tri),
  .codes    (chunk_codes)
);

// File: tb/sim_nand_ecc_gen.sv
module sim_nand_ecc_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       wide_blk = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       rd_req = 1'b0;
  logic [7:0] ecc_byte;
  logic       ecc_vld;

  always #5 clk = ~clk;

  nand_ecc_gen u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wide_blk(wide_blk),
    .byte_vld(byte_vld), .byte_data(byte_data), .rd_req(rd_req),
    .ecc_byte(ecc_byte), .ecc_vld(ecc_vld)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  mon_on = 1'b0;
  bit  done = 1'b0;

  // reference state
  bit [15:0] m_lp [2];
  bit [5:0]  m_cp [2];
  int        m_cnt = 0;
  int        b_tri = 0;
  int        b_pos = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  function automatic logic [7:0] model_byte(int t, int which);
    if (which == 0) return ~m_lp[t][7:0];
    if (which == 1) return ~m_lp[t][15:8];
    return {~m_cp[t], 2'b11};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_lp[c] = '0;
      m_cp[c] = '0;
    end
    m_cnt = 0;
  endtask

  // bit-by-bit restatement of the code
  task automatic model_take(logic [7:0] d);
    int c;
    int i;
    c = wide_blk ? ((m_cnt >> 8) & 1) : 0;
    i = m_cnt & 255;
    for (int b = 0; b < 8; b++) begin
      if (d[b]) begin
        for (int k = 0; k < 8; k++) m_lp[c][2*k + ((i >> k) & 1)] ^= 1'b1;
        for (int j = 0; j < 3; j++) m_cp[c][2*j + ((b >> j) & 1)] ^= 1'b1;
      end
    end
    m_cnt = (m_cnt + 1) % 512;
  endtask

  task automatic set_mode(logic [1:0] m, bit w);
    @(negedge clk);
    mode = m; wide_blk = w; byte_vld = 0; rd_req = 0;
    if (m == 2'b11) model_clear();
    b_tri = 0; b_pos = 0;
  endtask

  // one clock of stimulus; pushes the expected read result
  task automatic tick(bit v, logic [7:0] d, bit rq, string tag);
    @(negedge clk);
    byte_vld = v; byte_data = d; rd_req = rq;
    if (v && mode == 2'b01) model_take(d);
    if (rq && mode == 2'b10) begin
      exp_q.push_back(model_byte(b_tri, (b_pos == 0) ? 1 : (b_pos == 1) ? 0 : 2));
      tag_q.push_back(tag);
      if (b_pos == 2) begin
        b_pos = 0;
        b_tri = (wide_blk && b_tri == 0) ? 1 : 0;
      end else b_pos++;
    end
  endtask

  task automatic read_n(int n, string tag);
    for (int k = 0; k < n; k++) tick(1'b0, 8'h00, 1'b1, tag);
    tick(1'b0, 8'h00, 1'b0, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && ecc_vld) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6: unexpected ecc_vld byte %02h expected none", ecc_byte);
      end else begin
        check(tag_q.pop_front(), ecc_byte, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 vld", {7'd0, ecc_vld}, 8'h00);
    check("R1 byte", ecc_byte, 8'h00);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 fresh readout is erased code
    set_mode(2'b10, 1'b0);
    read_n(3, "R1 fresh");
    set_mode(2'b00, 1'b0);

    // R4 R5 R8 narrow block, reads wrap after 3
    set_mode(2'b11, 1'b0);
    set_mode(2'b00, 1'b0);
    set_mode(2'b01, 1'b0);
    for (int i = 0; i < 256; i++) tick(1'b1, 8'((i * 37 + 5) & 255), 1'b0, "R4");
    set_mode(2'b00, 1'b0);
    set_mode(2'b10, 1'b0);
    read_n(4, "R8 narrow");
    set_mode(2'b00, 1'b0);

    // R3 bytes in stop and readout are ignored (readout overlapped with reads)
    for (int i = 0; i < 20; i++) tick(1'b1, 8'(i * 11), 1'b0, "R3");
    set_mode(2'b10, 1'b0);
    for (int i = 0; i < 3; i++) tick(1'b1, 8'(i + 200), 1'b1, "R3 overlap");
    tick(1'b0, 8'h00, 1'b0, "R3");
    set_mode(2'b00, 1'b0);

    // R6 read request outside readout gives no byte; byte is taken
    set_mode(2'b01, 1'b0);
    tick(1'b1, 8'h3c, 1'b1, "R6");
    @(negedge clk);
    check("R6 no vld", {7'd0, ecc_vld}, 8'h00);
    byte_vld = 0; rd_req = 0;
    set_mode(2'b10, 1'b0);
    read_n(3, "R6 code after accumulate");

    // R2 clear returns to erased code
    set_mode(2'b11, 1'b0);
    set_mode(2'b00, 1'b0);
    set_mode(2'b10, 1'b0);
    read_n(3, "R2 cleared");

    // R7 wide block, two triplets and wrap on seventh read
    set_mode(2'b11, 1'b1);
    set_mode(2'b01, 1'b1);
    for (int i = 0; i < 512; i++) tick(1'b1, 8'((i ^ (i >> 3)) * 13 + 1), 1'b0, "R7");
    set_mode(2'b00, 1'b1);
    set_mode(2'b10, 1'b1);
    read_n(7, "R7 wide");

    // R9 pointer restarts after leaving readout
    set_mode(2'b00, 1'b1);
    set_mode(2'b10, 1'b1);
    read_n(2, "R9 partial");
    set_mode(2'b00, 1'b1);
    set_mode(2'b10, 1'b1);
    read_n(3, "R9 restart");

    // R4 single set bit in a zero chunk; chunk 1 untouched in wide mode
    set_mode(2'b11, 1'b1);
    set_mode(2'b01, 1'b1);
    for (int i = 0; i < 256; i++) tick(1'b1, (i == 90) ? 8'h10 : 8'h00, 1'b0, "R4");
    set_mode(2'b10, 1'b1);
    read_n(6, "R4 single bit");

    // R2 erased 512-byte block gives all 0xFF
    set_mode(2'b11, 1'b1);
    set_mode(2'b01, 1'b1);
    for (int i = 0; i < 512; i++) tick(1'b1, 8'hff, 1'b0, "R2");
    set_mode(2'b10, 1'b1);
    read_n(6, "R2 erased block");

    // R10 clear mid-block restarts the count at chunk 0
    set_mode(2'b11, 1'b1);
    set_mode(2'b01, 1'b1);
    for (int i = 0; i < 100; i++) tick(1'b1, 8'(i + 7), 1'b0, "R10");
    set_mode(2'b11, 1'b1);
    set_mode(2'b01, 1'b1);
    for (int i = 0; i < 300; i++) tick(1'b1, 8'(i * 3 + 1), 1'b0, "R10");
    set_mode(2'b10, 1'b1);
    read_n(6, "R10 count restart");
    set_mode(2'b00, 1'b0);

    repeat (4) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R6: %0d reads unanswered expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule